// File: doc/BRIEF.md
# Control-Code Warp Issue Scheduler

This block picks, every clock cycle, at most one warp out of a pool of resident warps and issues that warp's next instruction. Register dependencies are not tracked in hardware. Each instruction instead carries a 21-bit control field written by the compiler. The field gives a fixed stall count, a yield hint, up to two dependency-barrier indices that the instruction raises, and a mask of barriers that the instruction must wait on.

For each warp the scheduler keeps a stall down-counter and six barrier counters. Variable-latency units report completions as a warp id plus a barrier index, and each completion releases one count. A warp is eligible when all of the following hold:

- it presents an instruction;
- its stall counter is zero;
- no barrier in the instruction's wait mask is pending.

The scheduler chooses among eligible warps with a greedy round-robin policy, and the yield hint hands priority to the other warps.

The block sits between the instruction-fetch buffers, which present one control field per warp, and the dispatch path, which consumes the issued warp id.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every stall counter and barrier count is zero. The round-robin start is warp 0. A warp with a valid instruction and no pending waits is eligible at once.
- R2: Control field layout: stall count in bits [3:0], yield in bit 4, write-barrier index in [7:5], read-barrier index in [10:8], wait mask in [16:11] (bit 11+b is barrier b), operand-reuse bits in [20:17]. The reuse bits have no effect on eligibility or selection.
- R3: When a warp issues with stall count S, it is ineligible for the next S cycles and may issue again in the cycle after that.
- R4: Issuing with a write or read barrier index from 0 to 5 adds one to that barrier of the issuing warp. Indices 6 and 7 raise no barrier. When both indices name the same barrier, it gains two counts.
- R5: A warp is ineligible while any barrier named in its instruction's wait mask has a nonzero count.
- R6: Barriers count. Each completion (warp id, barrier index 0 to 5) removes one count from that barrier of that warp only, so a barrier raised twice needs two completions to clear.
- R7: When a raise and a completion hit the same barrier in the same cycle, and the count was nonzero, the count stays unchanged.
- R8: At most one warp issues per cycle. The issued warp is eligible. An issue occurs whenever any warp is eligible.
- R9: The search order starts at the warp that issued last if it did not yield, then continues in ascending warp order with wraparound.
- R10: When the issuing warp's yield bit is set, the search in the following cycle starts at the next warp, so the yielding warp has the lowest priority.
- R11: A completion addressed to a barrier whose count is zero is ignored, and the count stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inst_valid_i | input | NUM_WARPS | Warp w presents a next instruction |
| ctrl_i | input | NUM_WARPS*21 | Control field of each warp's next instruction, warp w at [21w +: 21] |
| cmpl_valid_i | input | 1 | A barrier completion event is present |
| cmpl_warp_i | input | clog2(NUM_WARPS) | Warp addressed by the completion |
| cmpl_bar_i | input | 3 | Barrier index addressed by the completion |
| eligible_o | output | NUM_WARPS | Per-warp eligibility in this cycle |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_warp_o | output | clog2(NUM_WARPS) | Warp that issues this cycle |

## Verification
The bench aims at barriers that count above one. A design that holds a barrier as a single flag would release a warp after the first of two loads completes.

It drives a raise and a completion onto the same barrier in one cycle. A design that lets either update win would leave the count off by one.

It also sends completions to barriers that are already clear. A design that wraps the count there would deadlock the warp.

The stall check targets an off-by-one hold in either direction. The priority checks confirm that a non-yielding warp issues back to back, and that a yielding warp steps aside even when it is eligible again.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int CTRL_W   = 21;
  localparam int NUM_BARS = 6;
  localparam int STALL_W  = 4;
  localparam int BIDX_W   = 3;

  typedef struct packed {
    logic [3:0]          reuse;
    logic [NUM_BARS-1:0] wait_mask;
    logic [BIDX_W-1:0]   rd_bar;
    logic [BIDX_W-1:0]   wr_bar;
    logic                yield;
    logic [STALL_W-1:0]  stall;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] raw);
    return ctrl_t'(raw);
  endfunction
endpackage

// File: rtl/warp_sched_decode.sv
module warp_sched_decode
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 12
) (
  input  logic [NUM_WARPS*CTRL_W-1:0] raw_i,
  output ctrl_t                       dec_o [NUM_WARPS]
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_dec
    assign dec_o[w] = decode_ctrl(raw_i[w*CTRL_W +: CTRL_W]);
  end
endmodule

// File: rtl/warp_sched_warp.sv
module warp_sched_warp
  import warp_sched_pkg::*;
#(
  parameter int BCNT_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  ctrl_t               ctrl_i,
  input  logic                issue_i,
  input  logic                cmpl_i,
  input  logic [BIDX_W-1:0]   cmpl_bar_i,
  output logic                elig_o,
  output logic [NUM_BARS-1:0] pend_o
);
  localparam int CMAX = (1 << BCNT_W) - 1;

  logic [STALL_W-1:0] stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              stall_q <= '0;
    else if (issue_i)         stall_q <= ctrl_i.stall;
    else if (stall_q != '0)   stall_q <= stall_q - 1'b1;
  end

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    logic [BCNT_W-1:0] cnt_q;
    logic [1:0]        inc;
    logic              dec;

    assign inc = issue_i ? ({1'b0, ctrl_i.wr_bar == BIDX_W'(b)} +
                            {1'b0, ctrl_i.rd_bar == BIDX_W'(b)}) : 2'd0;
    assign dec = cmpl_i && (cmpl_bar_i == BIDX_W'(b)) && (cnt_q != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + BCNT_W'(inc) - BCNT_W'(dec);
    end

    assign pend_o[b] = (cnt_q != '0);

    assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc != 2'd0) |-> (int'(cnt_q) + int'(inc) <= CMAX));

    assert_bar_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && ctrl_i.wr_bar == BIDX_W'(b) && !(cmpl_i && cmpl_bar_i == BIDX_W'(b)))
      |=> pend_o[b]);

    assert_clear_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmpl_i && cmpl_bar_i == BIDX_W'(b) && cnt_q == '0 && inc == 2'd0)
      |=> (cnt_q == '0));
  end

  assign elig_o = valid_i && (stall_q == '0) && ((ctrl_i.wait_mask & pend_o) == '0);

  assert_stall_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && ctrl_i.stall != '0) |=> !elig_o);

  assert_wait_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && ctrl_i.wr_bar < BIDX_W'(NUM_BARS) && !cmpl_i && valid_i &&
     ctrl_i.wait_mask[ctrl_i.wr_bar[2:0]]) |=> (!elig_o || !$stable(ctrl_i)));
endmodule

// File: rtl/warp_sched_rr.sv
module warp_sched_rr #(
  parameter int NUM_WARPS = 12,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] req_i,
  input  logic                 yield_i,
  output logic                 gnt_valid_o,
  output logic [WID_W-1:0]     gnt_idx_o
);
  logic [WID_W-1:0] ptr_q;

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = NUM_WARPS - 1; k >= 0; k--) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= NUM_WARPS) j = j - NUM_WARPS;
      if (req_i[j]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = WID_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (gnt_valid_o) begin
      if (!yield_i)                                  ptr_q <= gnt_idx_o;
      else if (gnt_idx_o == WID_W'(NUM_WARPS - 1))   ptr_q <= '0;
      else                                           ptr_q <= gnt_idx_o + 1'b1;
    end
  end

  assert_grant_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> req_i[gnt_idx_o]);

  assert_grant_any_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> gnt_valid_o);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 12,
  parameter int BCNT_W    = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_WARPS-1:0]          inst_valid_i,
  input  logic [NUM_WARPS*21-1:0]       ctrl_i,
  input  logic                          cmpl_valid_i,
  input  logic [$clog2(NUM_WARPS)-1:0]  cmpl_warp_i,
  input  logic [2:0]                    cmpl_bar_i,
  output logic [NUM_WARPS-1:0]          eligible_o,
  output logic                          issue_valid_o,
  output logic [$clog2(NUM_WARPS)-1:0]  issue_warp_o
);
  localparam int WID_W = $clog2(NUM_WARPS);

  ctrl_t                dec [NUM_WARPS];
  logic [NUM_WARPS-1:0] iss_vec;
  logic [NUM_BARS-1:0]  pend [NUM_WARPS];
  logic                 iss_yield;

  warp_sched_decode #(.NUM_WARPS(NUM_WARPS)) u_dec (
    .raw_i (ctrl_i),
    .dec_o (dec)
  );

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign iss_vec[w] = issue_valid_o && (issue_warp_o == WID_W'(w));

    warp_sched_warp #(.BCNT_W(BCNT_W)) u_warp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (inst_valid_i[w]),
      .ctrl_i     (dec[w]),
      .issue_i    (iss_vec[w]),
      .cmpl_i     (cmpl_valid_i && (cmpl_warp_i == WID_W'(w))),
      .cmpl_bar_i (cmpl_bar_i),
      .elig_o     (eligible_o[w]),
      .pend_o     (pend[w])
    );
  end

  assign iss_yield = dec[issue_warp_o].yield;

  warp_sched_rr #(.NUM_WARPS(NUM_WARPS)) u_rr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (eligible_o),
    .yield_i     (iss_yield),
    .gnt_valid_o (issue_valid_o),
    .gnt_idx_o   (issue_warp_o)
  );

  assert_one_issue_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(iss_vec));

  assert_greedy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !iss_yield) |=>
      (eligible_o[$past(issue_warp_o)] |-> issue_warp_o == $past(issue_warp_o)));

  assert_yield_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && iss_yield) |=>
      (($countones(eligible_o) > 1) |-> issue_warp_o != $past(issue_warp_o)));
endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  localparam int NW = 12;
  localparam int NB = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NW-1:0]   v;
  logic [20:0]     c [NW];
  logic [NW*21-1:0] ctrl_flat;
  logic            cv;
  logic [3:0]      cw;
  logic [2:0]      cb;
  logic [NW-1:0]   elig;
  logic            iv;
  logic [3:0]      iw;

  int m_st [NW];
  int m_cnt [NW][NB];
  int m_ptr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb
    for (int w = 0; w < NW; w++) ctrl_flat[w*21 +: 21] = c[w];

  warp_issue_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .inst_valid_i(v), .ctrl_i(ctrl_flat),
    .cmpl_valid_i(cv), .cmpl_warp_i(cw), .cmpl_bar_i(cb),
    .eligible_o(elig), .issue_valid_o(iv), .issue_warp_o(iw)
  );

  function automatic logic [20:0] mk(int st, int y, int wr, int rd, int wm, int ru);
    return {4'(ru), 6'(wm), 3'(rd), 3'(wr), 1'(y), 4'(st)};
  endfunction

  function automatic logic [20:0] idle_ctrl();
    return mk(0, 0, 7, 7, 0, 0);
  endfunction

  task automatic clear_in();
    v = '0; cv = 1'b0; cw = '0; cb = '0;
    for (int w = 0; w < NW; w++) c[w] = idle_ctrl();
  endtask

  // caller sets inputs after a negedge; checks, updates model, moves to next negedge
  task automatic step(string tag);
    logic [NW-1:0] e_el;
    bit            e_iv;
    int            e_iw;
    #1;
    e_el = '0;
    for (int w = 0; w < NW; w++) begin
      bit blk = 0;
      for (int b = 0; b < NB; b++) if (c[w][11+b] && m_cnt[w][b] > 0) blk = 1;
      e_el[w] = v[w] && m_st[w] == 0 && !blk;
    end
    e_iv = 0; e_iw = 0;
    for (int k = 0; k < NW; k++) begin
      int j = (m_ptr + k) % NW;
      if (!e_iv && e_el[j]) begin e_iv = 1; e_iw = j; end
    end
    n_chk++;
    if (elig !== e_el || iv !== e_iv || (e_iv && iw !== 4'(e_iw))) begin
      n_fail++;
      $display("FAIL %s: elig=%h iv=%0b iw=%0d expected elig=%h iv=%0b iw=%0d",
               tag, elig, iv, iw, e_el, e_iv, e_iw);
    end
    // model update
    if (cv && cb < 3'(NB) && cw < 4'(NW))
      if (m_cnt[cw][cb] > 0) m_cnt[cw][cb]--;
    for (int w = 0; w < NW; w++)
      if (!(e_iv && e_iw == w) && m_st[w] > 0) m_st[w]--;
    if (e_iv) begin
      logic [20:0] x = c[e_iw];
      m_st[e_iw] = int'(x[3:0]);
      if (x[7:5] < 3'(NB)) m_cnt[e_iw][x[7:5]]++;
      if (x[10:8] < 3'(NB)) m_cnt[e_iw][x[10:8]]++;
      m_ptr = x[4] ? (e_iw + 1) % NW : e_iw;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R8: watchdog expired, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < NW; w++) begin
      m_st[w] = 0;
      for (int b = 0; b < NB; b++) m_cnt[w][b] = 0;
    end
    m_ptr = 0;
    clear_in();
    repeat (3) @(negedge clk);
    step("R1 reset idle");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all valid, nothing pending, warp 0 wins from reset pointer
    v = '1;
    step("R1 after reset all eligible");
    clear_in();

    // R3: stall of 5 on warp 3
    v[3] = 1'b1; c[3] = mk(5, 0, 7, 7, 0, 0);
    step("R3 issue stall5");
    c[3] = idle_ctrl();
    for (int i = 0; i < 7; i++) step("R3 stall hold");

    // R6: double raise on barrier 1 of warp 2
    clear_in();
    v[2] = 1'b1; c[2] = mk(0, 0, 1, 1, 0, 0);
    step("R4 R6 double raise");
    c[2] = mk(0, 0, 7, 7, 6'b000010, 0);
    step("R5 blocked on bar1");
    cv = 1'b1; cw = 4'd2; cb = 3'd1;
    step("R6 first completion");
    cv = 1'b0;
    step("R6 still blocked");
    cv = 1'b1;
    step("R6 second completion");
    cv = 1'b0;
    step("R6 released");

    // R11: completion to an empty barrier
    v = '0; cv = 1'b1; cw = 4'd2; cb = 3'd4;
    step("R11 empty completion");
    cv = 1'b0; v[2] = 1'b1; c[2] = mk(0, 0, 7, 7, 6'b010000, 0);
    step("R11 bar4 still clear");

    // R7: simultaneous raise and completion on bar0 of warp 5
    clear_in();
    v[5] = 1'b1; c[5] = mk(0, 0, 0, 7, 0, 0);
    step("R7 first raise");
    cv = 1'b1; cw = 4'd5; cb = 3'd0;
    step("R7 raise plus completion");
    cv = 1'b0; c[5] = mk(0, 0, 7, 7, 6'b000001, 0);
    step("R7 count kept");
    cv = 1'b1;
    step("R7 final completion");
    cv = 1'b0;
    step("R7 released");

    // R4: index 6 raises nothing
    clear_in();
    v[7] = 1'b1; c[7] = mk(0, 0, 6, 6, 0, 0);
    step("R4 index6 issue");
    c[7] = mk(0, 0, 7, 7, 6'b111111, 0);
    step("R4 index6 no barrier");

    // R2: reuse bits ignored
    clear_in();
    v[8] = 1'b1; c[8] = mk(0, 0, 7, 7, 0, 15);
    step("R2 reuse set");
    step("R2 reuse set again");

    // R9 greedy, R10 yield
    clear_in();
    v = '1;
    step("R9 greedy first");
    step("R9 greedy repeat");
    for (int w = 0; w < NW; w++) c[w] = mk(0, 1, 7, 7, 0, 0);
    step("R10 yield issue");
    step("R10 next warp");
    step("R10 next warp again");

    // random mix
    clear_in();
    for (int i = 0; i < 4000; i++) begin
      for (int w = 0; w < NW; w++) begin
        int st = ($urandom % 8 == 0) ? int'($urandom % 16) : int'($urandom % 4);
        int wr = int'($urandom % 8);
        int rd = ($urandom % 3 == 0) ? int'($urandom % 8) : 7;
        int wm = int'($urandom % 64 & $urandom % 64 & $urandom % 64);
        if (wr < NB && m_cnt[w][wr] >= 5) wr = 7;
        if (rd < NB && m_cnt[w][rd] >= 5) rd = 7;
        v[w] = ($urandom % 5) != 0;
        c[w] = mk(st, int'($urandom % 2), wr, rd, wm, int'($urandom % 16));
      end
      cv = ($urandom % 10) < 7;
      cw = 4'($urandom % NW);
      cb = 3'($urandom % 8);
      if ($urandom % 8 != 0) begin
        for (int k = 0; k < NW * NB; k++) begin
          int ww = (int'(cw) + k / NB) % NW;
          int bb = k % NB;
          if (m_cnt[ww][bb] > 0) begin cw = 4'(ww); cb = 3'(bb); break; end
        end
      end
      step("R5 R8 R9 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule